// File: doc/BRIEF.md
# Six-Channel Digital Attenuator with Soft Mute

This block scales six signed 24-bit playback channels, each by its own logarithmic gain picked by an 8-bit attenuation code. A code of 255 passes the sample through unchanged. Every step below 255 lowers the gain by half a decibel, and code 0 silences the channel. Gains come from a coefficient computed inside the block, with no stored table. The product is rounded and then saturated back to 24 bits.

A single mute request fades all channels together rather than cutting them off. While the request is high, a shared mute depth rises by one on every sample strobe. Each channel runs at its code minus that depth, floored at zero. When the request drops, the depth falls again one step per strobe, so the channels return to their programmed levels. The ramp reverses from wherever it stands. A flag reports that the depth has reached its end, which is the point where every channel is silent.

The block takes one set of six samples per strobe and returns the scaled set one cycle later.

Top module: `chan_atten_mute`

## Requirements
- R1: Each channel's output depends only on that channel's own sample and its own attenuation code. Channel n uses bits [24n+23:24n] of the sample and output buses and bits [8n+7:8n] of the code bus.
- R2: The gain coefficient is Q15 (32768 = unity). For code c > 0, let s = 255 − c. The coefficient is round(32768·2^(−(s mod 12)/12)) shifted right by floor(s/12). Code 255 therefore reproduces the input exactly.
- R3: An effective code of 0 yields an output of exactly 0.
- R4: Output = floor((x·coef + 16384) / 32768), clamped to the range −8388608 to 8388607.
- R5: out_valid is high in exactly the cycle after each in_valid cycle. out_data changes only after a strobe and holds otherwise.
- R6: While mute_req is high, each strobe raises the mute depth by one, up to 255. A strobe uses the depth as it stood before that strobe's step. Effective code = max(code − depth, 0).
- R7: While mute_req is low, each strobe lowers the depth by one until it reaches 0. At depth 0 the outputs are back at the programmed gain.
- R8: Changing mute_req partway through a ramp reverses the ramp from the current depth, with no jump.
- R9: mute_done is high exactly when the depth equals 255.
- R10: During reset, out_data is 0, out_valid is 0, mute_done is 0, and the depth is set to 0.
- R11: Cycles without a strobe leave the depth unchanged, whatever mute_req does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe, one cycle per sample set |
| in_data | input | 144 | Six signed 24-bit samples, channel 0 in the low bits |
| att_code | input | 48 | Six 8-bit attenuation codes, 255 = 0 dB, 0 = silent |
| mute_req | input | 1 | Soft mute request, level sensitive |
| out_valid | output | 1 | Scaled samples available |
| out_data | output | 144 | Six signed 24-bit scaled samples |
| mute_done | output | 1 | Mute depth at its end, all channels silent |

## Verification
A wrong mute depth scales all six channels by the same wrong number of half-decibel steps. That error appears on the first strobe after it arises, and from then on mute_done falls out of step with the count of strobes. A bad coefficient for one code shows up in the first sample processed at that code, so the bench sweeps every code on every channel with full-scale and mixed samples. Faults in rounding or clamping show up only at odd products and at the extreme sample values, and the sweep includes those values.

// File: rtl/dattn_pkg.sv
package dattn_pkg;

  // 12 half-decibel steps make one factor-of-two octave
  localparam int unsigned OCT_STEPS = 12;
  localparam int unsigned FRAC_W    = 15;
  localparam int unsigned COEF_W    = FRAC_W + 1;

  typedef logic [COEF_W-1:0] coef_t;

  // Q15 mantissa of 2^(-k/12) for one position inside an octave
  function automatic coef_t octave_mant(input logic [3:0] k);
    case (k)
      4'd0:    return 16'd32768;
      4'd1:    return 16'd30929;
      4'd2:    return 16'd29193;
      4'd3:    return 16'd27554;
      4'd4:    return 16'd26008;
      4'd5:    return 16'd24548;
      4'd6:    return 16'd23170;
      4'd7:    return 16'd21870;
      4'd8:    return 16'd20643;
      4'd9:    return 16'd19484;
      4'd10:   return 16'd18390;
      4'd11:   return 16'd17358;
      default: return 16'd0;
    endcase
  endfunction

  // Gain coefficient for an effective code; code 0 is silence
  function automatic coef_t code_to_coef(input int unsigned code,
                                         input int unsigned max_code);
    int unsigned s;
    if (code == 0) return '0;
    s = max_code - code;
    return octave_mant(4'(s % OCT_STEPS)) >> (s / OCT_STEPS);
  endfunction

endpackage

// File: rtl/dattn_ramp.sv
module dattn_ramp #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          mute_req,
  output logic [CW-1:0] depth,
  output logic          at_floor
);

  localparam logic [CW-1:0] FULL = '1;

  logic deepen, recover;

  assign deepen  = step_en &&  mute_req && (depth != FULL);
  assign recover = step_en && !mute_req && (depth != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       depth <= '0;
    else if (deepen)  depth <= depth + 1'b1;
    else if (recover) depth <= depth - 1'b1;
  end

  assign at_floor = (depth == FULL);

  assert_no_step_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(depth));

  assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && mute_req && at_floor |=> at_floor);

  assert_rise_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(at_floor) |-> $past(mute_req));

  assert_release_leaves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !mute_req && at_floor |=> !at_floor);

endmodule

// File: rtl/dattn_chan.sv
module dattn_chan
  import dattn_pkg::*;
#(
  parameter int DW = 24,
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [DW-1:0] sample,
  input  logic [CW-1:0]        code,
  input  logic [CW-1:0]        depth,
  output logic signed [DW-1:0] out_sample
);

  localparam int PW       = DW + COEF_W + 1;
  localparam int MAX_CODE = (1 << CW) - 1;

  logic [CW-1:0] eff_code;
  coef_t         coef;

  function automatic logic signed [DW-1:0] apply_gain(
    input logic signed [DW-1:0] x, input coef_t c);
    logic signed [PW-1:0] xe, ce, p, r, hi, lo;
    xe = PW'(x);
    ce = PW'($signed({1'b0, c}));
    p  = xe * ce;
    r  = (p + (PW'(1) <<< (FRAC_W - 1))) >>> FRAC_W;
    hi = (PW'(1) <<< (DW - 1)) - PW'(1);
    lo = -(PW'(1) <<< (DW - 1));
    if (r > hi)      return {1'b0, {(DW-1){1'b1}}};
    else if (r < lo) return {1'b1, {(DW-1){1'b0}}};
    else             return r[DW-1:0];
  endfunction

  function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
    logic signed [DW:0] w;
    w = {v[DW-1], v};
    return (w < 0) ? $unsigned(-w) : $unsigned(w);
  endfunction

  assign eff_code = (code > depth) ? (code - depth) : '0;
  assign coef     = code_to_coef(32'(eff_code), MAX_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_sample <= '0;
    else if (load) out_sample <= apply_gain(sample, coef);
  end

  assert_silent_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load && (eff_code == '0) |=> out_sample == '0);

  assert_unity_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load && (eff_code == '1) |=> out_sample == $past(sample));

  assert_no_growth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> mag(out_sample) <= mag($past(sample)));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(out_sample));

endmodule

// File: rtl/chan_atten_mute.sv
module chan_atten_mute #(
  parameter int NCH = 6,
  parameter int DW  = 24,
  parameter int CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_data,
  input  logic [NCH*CW-1:0] att_code,
  input  logic              mute_req,
  output logic              out_valid,
  output logic [NCH*DW-1:0] out_data,
  output logic              mute_done
);

  logic [CW-1:0] mute_depth;
  logic          ramp_full;

  dattn_ramp #(.CW(CW)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (in_valid),
    .mute_req (mute_req),
    .depth    (mute_depth),
    .at_floor (ramp_full)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic signed [DW-1:0] scaled;
    dattn_chan #(.DW(DW), .CW(CW)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (in_valid),
      .sample     (in_data[g*DW +: DW]),
      .code       (att_code[g*CW +: CW]),
      .depth      (mute_depth),
      .out_sample (scaled)
    );
    assign out_data[g*DW +: DW] = scaled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  assign mute_done = ramp_full;

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_silent_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mute_done |=> out_data == '0);

endmodule

// File: tb/chan_atten_mute_tb.sv
`timescale 1ns/1ps
module chan_atten_mute_tb;

  localparam int NCH = 6;
  localparam int DW  = 24;
  localparam int CW  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [NCH*DW-1:0] in_data;
  logic [NCH*CW-1:0] att_code;
  logic              mute_req;
  logic              out_valid;
  logic [NCH*DW-1:0] out_data;
  logic              mute_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  int mdepth = 0;
  int unsigned seed = 32'h1234_5678;

  logic signed [DW-1:0] smp [NCH];
  logic [CW-1:0]        cd  [NCH];

  always #2.5 clk = ~clk;

  chan_atten_mute #(.NCH(NCH), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .att_code(att_code), .mute_req(mute_req), .out_valid(out_valid),
    .out_data(out_data), .mute_done(mute_done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Gain from the formula in R2, evaluated in floating point
  function automatic longint exp_coef(input int code);
    int s, k, e;
    longint m;
    if (code == 0) return 0;
    s = 255 - code;
    k = s % 12;
    e = s / 12;
    m = longint'($rtoi(32768.0 * (2.0 ** (-real'(k) / 12.0)) + 0.5));
    return m >>> e;
  endfunction

  // Rounding and clamping as stated in R4
  function automatic longint exp_out(input longint x, input int code);
    longint p, y;
    p = x * exp_coef(code);
    y = (p + 16384) >>> 15;
    if (y > 8388607)  y = 8388607;
    if (y < -8388608) y = -8388608;
    return y;
  endfunction

  function automatic logic signed [DW-1:0] next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:7];
  endfunction

  task automatic strobe(input string rtag);
    int eff;
    longint e, a;
    string tag;
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) begin
      in_data[ch*DW +: DW]  = smp[ch];
      att_code[ch*CW +: CW] = cd[ch];
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R5", "out_valid after strobe", longint'(out_valid), 1);
    for (int ch = 0; ch < NCH; ch++) begin
      eff = (int'(cd[ch]) > mdepth) ? int'(cd[ch]) - mdepth : 0;
      e = exp_out(longint'(smp[ch]), eff);
      a = longint'($signed(out_data[ch*DW +: DW]));
      if (mdepth != 0)  tag = rtag;
      else if (eff == 0)   tag = "R3";
      else if (eff == 255) tag = "R2";
      else                 tag = "R4";
      chk(a == e, tag, $sformatf("ch%0d code %0d depth %0d", ch, cd[ch], mdepth), a, e);
    end
    if (mute_req && mdepth < 255) mdepth++;
    else if (!mute_req && mdepth > 0) mdepth--;
    chk(mute_done === (mdepth == 255), "R9", "mute_done", longint'(mute_done),
        longint'(mdepth == 255));
  endtask

  task automatic rand_samples();
    for (int ch = 0; ch < NCH; ch++) smp[ch] = next_rand();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL R5 watchdog expired: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NCH*DW-1:0] snap;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; att_code = '0; mute_req = 1'b0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(out_valid === 1'b0, "R10", "out_valid in reset", longint'(out_valid), 0);
    chk(out_data === '0, "R10", "out_data in reset", longint'(out_data[23:0]), 0);
    chk(mute_done === 1'b0, "R10", "mute_done in reset", longint'(mute_done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R2, R3, R4: every code on every channel, channels offset from each other
    for (int i = 0; i < 256; i++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        cd[ch] = CW'((i + 43 * ch) % 256);
        case ((i + ch) % 5)
          0: smp[ch] = 24'sh7FFFFF;
          1: smp[ch] = 24'sh800000;
          2: smp[ch] = 24'sh000001;
          default: smp[ch] = next_rand();
        endcase
      end
      strobe("R1");
    end

    // R5, R11: idle cycles with mute requested leave outputs and depth alone
    for (int ch = 0; ch < NCH; ch++) cd[ch] = CW'(255 - 37 * ch);
    rand_samples();
    strobe("R6");
    snap = out_data;
    mute_req = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R5", "out_valid idle", longint'(out_valid), 0);
      chk(out_data === snap, "R5", "out_data held", longint'(out_data[23:0]),
          longint'(snap[23:0]));
    end
    rand_samples();
    strobe("R11");

    // R6: ramp down part way
    for (int k = 0; k < 100; k++) begin rand_samples(); strobe("R6"); end
    // R8: reverse from the current depth
    mute_req = 1'b0;
    for (int k = 0; k < 40; k++) begin rand_samples(); strobe("R8"); end
    mute_req = 1'b1;
    for (int k = 0; k < 10; k++) begin rand_samples(); strobe("R8"); end
    // R6, R9: run to full mute and past it
    for (int k = 0; k < 300; k++) begin rand_samples(); strobe("R6"); end
    chk(mute_done === 1'b1, "R9", "mute_done at full depth", longint'(mute_done), 1);
    // R7: release back to the programmed gain
    mute_req = 1'b0;
    for (int k = 0; k < 262; k++) begin rand_samples(); strobe("R7"); end
    chk(mute_done === 1'b0, "R7", "mute_done after release", longint'(mute_done), 0);
    chk(mdepth == 0, "R7", "model depth back to zero", longint'(mdepth), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule